// File: doc/BRIEF.md
# Iterative Polynomial Cosine Unit

This block returns the cosine of a signed fixed-point argument that lies between zero and pi/4. It evaluates an even polynomial of degree 12 in Horner form on the squared argument. Its value is 1 − x²/2 + C1·x⁴ + C2·x⁶ + C3·x⁸ + C4·x¹⁰ + C5·x¹². One multiplier, one rounding stage and one accumulator register are shared across all of the steps.

When a start is accepted, the argument is captured and the accumulator is preloaded with C5. The next cycle squares the argument into a register z. Six multiply-accumulate iterations follow, each taking three cycles. Every iteration computes R = R·z + k, where k takes the values C4, C3, C2, C1, −1/2 and then 1. A final cycle rounds the internal value to the output format and raises done.

Argument and result are signed 16-bit Q2.14. Internal values are signed 32-bit Q4.28. The coefficients C1 to C5 are parameters written in the internal Q4.28 format. The start pin is a plain strobe with no back-pressure: a start that arrives while the unit is busy is dropped, so the caller must watch busy or done. An argument outside the valid interval is still evaluated, and out_of_range is raised alongside the result.

Top module: `cos_poly_mac`

## Requirements
- R1: After reset, busy, done, out_of_range and result are all 0.
- R2: A start seen at a rising edge while busy is low is accepted. busy is high from that edge until the 20th edge after it. At that 20th edge busy falls and done goes high for exactly one cycle.
- R3: For every argument in 0..12868 (0 to pi/4 in Q2.14, with 1.0 = 16384), the result is within 4 LSB of 16384·cos(arg/16384).
- R4: An argument of 0 gives a result of exactly 16384 (1.0).
- R5: A start seen while busy is high is ignored. It produces no extra done pulse and no extra busy time, and the result belongs to the argument that was accepted.
- R6: out_of_range is 1 together with the result when the accepted argument is negative or greater than 12868, and 0 otherwise. The polynomial value is still returned in both cases, for example within 4 LSB of 16384·cos(1.0) for an argument of 16384.
- R7: result and out_of_range change only at the edge that raises done, and hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a computation; ignored while busy |
| arg | input | 16 | Signed Q2.14 argument, sampled with an accepted start |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | 16 | Signed Q2.14 cosine value |
| out_of_range | output | 1 | Argument was negative or above pi/4 |

## Verification
Call the rising edge that accepts a start edge 0. busy is due high just after edge 0, and done, result and out_of_range are due just after edge 20, the same edge at which busy falls. The bench keeps a behavioural countdown model that follows the same acceptance rule, including dropping a start while busy. It compares busy and done against that model on every falling edge, and it checks the result against a real-valued cosine only in the cycle the model expects done. A few cycles after each done, the bench samples the outputs again to confirm that they hold their values.

// File: rtl/cos_poly_pkg.sv
package cos_poly_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SQ   = 2'd1,
    ST_MAC  = 2'd2,
    ST_OUT  = 2'd3
  } cos_state_t;

  localparam int MAC_ITERS  = 6;
  localparam int MAC_PHASES = 3;
  localparam int ITW        = $clog2(MAC_ITERS);
  localparam int PHW        = $clog2(MAC_PHASES);
  localparam int LATENCY    = 2 + MAC_ITERS * MAC_PHASES;
endpackage

// File: rtl/cos_sched.sv
module cos_sched
  import cos_poly_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           load,
  output logic           sq_en,
  output logic           mac_en,
  output logic [PHW-1:0] phase,
  output logic [ITW-1:0] iter,
  output logic           out_en,
  output logic           busy
);
  localparam int CNTW = $clog2(LATENCY + 1);

  cos_state_t state_q;
  logic [PHW-1:0] ph_q;
  logic [ITW-1:0] it_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      it_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_SQ;
        ST_SQ: begin
          state_q <= ST_MAC;
          ph_q    <= '0;
          it_q    <= '0;
        end
        ST_MAC: begin
          if (ph_q == PHW'(MAC_PHASES - 1)) begin
            ph_q <= '0;
            if (it_q == ITW'(MAC_ITERS - 1)) state_q <= ST_OUT;
            else it_q <= it_q + ITW'(1);
          end else begin
            ph_q <= ph_q + PHW'(1);
          end
        end
        ST_OUT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load   = (state_q == ST_IDLE) && start;
  assign sq_en  = (state_q == ST_SQ);
  assign mac_en = (state_q == ST_MAC);
  assign out_en = (state_q == ST_OUT);
  assign busy   = (state_q != ST_IDLE);
  assign phase  = ph_q;
  assign iter   = it_q;

  // cycle counter used only to check the fixed schedule length
  logic [CNTW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else if (load) lat_q <= CNTW'(1);
    else if (busy) lat_q <= lat_q + CNTW'(1);
    else lat_q <= '0;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (lat_q == CNTW'(LATENCY)));

  assert_ignore_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !out_en) |=> busy);
endmodule

// File: rtl/cos_mac_dp.sv
module cos_mac_dp
  import cos_poly_pkg::*;
#(
  parameter int IO_W    = 16,
  parameter int IO_FRAC = 14,
  parameter int C1      = 11184811,
  parameter int C2      = -372827,
  parameter int C3      = 6658,
  parameter int C4      = -74,
  parameter int C5      = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   sq_en,
  input  logic                   mac_en,
  input  logic [PHW-1:0]         phase,
  input  logic [ITW-1:0]         iter,
  input  logic signed [IO_W-1:0] arg,
  output logic [2*IO_W-1:0]      acc,
  output logic                   oor
);
  localparam int W    = 2 * IO_W;
  localparam int FRAC = 2 * IO_FRAC;
  localparam int PI4_Q = int'(0.7853981633974483 * (2.0 ** IO_FRAC));
  localparam logic [W-1:0] ONE_I  = W'(1) << FRAC;
  localparam logic [W-1:0] HALF_N = ~(W'(1) << (FRAC - 1)) + W'(1);
  localparam logic [2*W-1:0] RND  = (2*W)'(1) << (FRAC - 1);

  function automatic logic [W-1:0] coef_at(input logic [ITW-1:0] k);
    case (k)
      ITW'(0): coef_at = W'(C4);
      ITW'(1): coef_at = W'(C3);
      ITW'(2): coef_at = W'(C2);
      ITW'(3): coef_at = W'(C1);
      ITW'(4): coef_at = HALF_N;
      default: coef_at = ONE_I;
    endcase
  endfunction

  logic signed [IO_W-1:0] x_q;
  logic [W-1:0]   z_q, r_q, p_q;
  logic [2*W-1:0] full_q;
  logic [W-1:0]   x_ext, sq;
  logic [2*W-1:0] r_ext, z_ext, prod, prod_rnd;

  assign x_ext    = {{IO_W{x_q[IO_W-1]}}, x_q};
  assign sq       = x_ext * x_ext;
  assign r_ext    = {{W{r_q[W-1]}}, r_q};
  assign z_ext    = {{W{z_q[W-1]}}, z_q};
  assign prod     = r_ext * z_ext;
  assign prod_rnd = full_q + RND;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      z_q    <= '0;
      r_q    <= '0;
      p_q    <= '0;
      full_q <= '0;
      oor    <= 1'b0;
    end else begin
      if (load) begin
        x_q <= arg;
        r_q <= W'(C5);
        oor <= (arg < 0) || (int'(arg) > PI4_Q);
      end
      if (sq_en) z_q <= sq;
      if (mac_en) begin
        case (phase)
          PHW'(0): full_q <= prod;
          PHW'(1): p_q    <= prod_rnd[FRAC +: W];
          default: r_q    <= p_q + coef_at(iter);
        endcase
      end
    end
  end

  assign acc = r_q;

  assert_arg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en || sq_en) |=> $stable(x_q));
endmodule

// File: rtl/cos_out_stage.sv
module cos_out_stage #(
  parameter int IO_W    = 16,
  parameter int IO_FRAC = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en,
  input  logic [2*IO_W-1:0] acc,
  input  logic              oor_in,
  output logic [IO_W-1:0]   result,
  output logic              oor,
  output logic              done
);
  localparam int W = 2 * IO_W;
  localparam logic signed [W-1:0] HALF_O = W'(1) <<< (IO_FRAC - 1);
  localparam logic signed [W-1:0] MAXV = W'((1 << (IO_W - 1)) - 1);
  localparam logic signed [W-1:0] MINV = -(W'(1) <<< (IO_W - 1));

  logic signed [W-1:0] rounded, shifted;
  logic [IO_W-1:0] sat;

  assign rounded = $signed(acc) + HALF_O;
  assign shifted = rounded >>> IO_FRAC;

  always_comb begin
    if (shifted > MAXV)      sat = MAXV[IO_W-1:0];
    else if (shifted < MINV) sat = MINV[IO_W-1:0];
    else                     sat = shifted[IO_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      oor    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= out_en;
      if (out_en) begin
        result <= sat;
        oor    <= oor_in;
      end
    end
  end

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/cos_poly_mac.sv
module cos_poly_mac
  import cos_poly_pkg::*;
#(
  parameter int IO_W    = 16,
  parameter int IO_FRAC = 14,
  parameter int C1      = 11184811,
  parameter int C2      = -372827,
  parameter int C3      = 6658,
  parameter int C4      = -74,
  parameter int C5      = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IO_W-1:0] arg,
  output logic            busy,
  output logic            done,
  output logic [IO_W-1:0] result,
  output logic            out_of_range
);
  logic load, sq_en, mac_en, out_en, oor_dp;
  logic [PHW-1:0] phase;
  logic [ITW-1:0] iter;
  logic [2*IO_W-1:0] acc;

  cos_sched u_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load), .sq_en(sq_en),
    .mac_en(mac_en), .phase(phase), .iter(iter), .out_en(out_en), .busy(busy)
  );

  cos_mac_dp #(
    .IO_W(IO_W), .IO_FRAC(IO_FRAC),
    .C1(C1), .C2(C2), .C3(C3), .C4(C4), .C5(C5)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .sq_en(sq_en), .mac_en(mac_en),
    .phase(phase), .iter(iter), .arg($signed(arg)), .acc(acc), .oor(oor_dp)
  );

  cos_out_stage #(.IO_W(IO_W), .IO_FRAC(IO_FRAC)) u_out (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .acc(acc), .oor_in(oor_dp),
    .result(result), .oor(out_of_range), .done(done)
  );

  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(out_of_range)));
endmodule

// File: tb/cos_poly_mac_tb_top.sv
module cos_poly_mac_tb_top;
  localparam int LAT = 20;
  localparam int PI4 = 12868;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] arg = '0;
  logic busy, done, out_of_range;
  logic [15:0] result;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cos_poly_mac dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .arg(arg), .busy(busy),
    .done(done), .result(result), .out_of_range(out_of_range)
  );

  // behavioural timing model
  logic busy_m = 1'b0, done_m = 1'b0;
  int cnt_m = 0;
  int arg_m = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      busy_m <= 1'b0; done_m <= 1'b0; cnt_m <= 0;
    end else begin
      done_m <= 1'b0;
      if (!busy_m && start) begin
        busy_m <= 1'b1; cnt_m <= LAT; arg_m <= int'(arg);
      end else if (busy_m) begin
        cnt_m <= cnt_m - 1;
        if (cnt_m == 1) begin busy_m <= 1'b0; done_m <= 1'b1; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy === busy_m, "R2", "busy", int'(busy), int'(busy_m));
      check(done === done_m, "R2/R5", "done", int'(done), int'(done_m));
      if (done_m) begin
        real e;
        int r;
        bit ov;
        r  = int'($signed(result));
        e  = $cos(real'(arg_m) / 16384.0) * 16384.0;
        ov = (arg_m < 0) || (arg_m > PI4);
        if (arg_m == 0)
          check(r == 16384, "R4", "cos(0)", r, 16384);
        else
          check(($itor(r) - e <= 4.0) && (e - $itor(r) <= 4.0),
                ov ? "R6" : "R3", "result", r, $rtoi(e + 0.5));
        check(out_of_range === ov, "R6", "out_of_range",
              int'(out_of_range), int'(ov));
      end
    end
  end

  task automatic run_one(input int a);
    @(negedge clk);
    arg = 16'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done_m) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "busy/done", int'(busy), 0);
    check(result === 16'd0, "R1", "result", int'(result), 0);
    check(out_of_range === 1'b0, "R1", "out_of_range", int'(out_of_range), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_one(0);          // R4
    run_one(PI4);        // R3 upper endpoint
    run_one(PI4 + 1);    // R6 just beyond
    run_one(16384);      // R6 value 1.0
    run_one(-8192);      // R6 negative
    for (int a = 1; a <= PI4; a += 97) run_one(a);   // R3 sweep

    // R5: start while busy is dropped
    @(negedge clk);
    arg = 16'sd8000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    arg = 16'sd100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done_m) @(negedge clk);
    check(arg_m == 8000, "R5", "accepted argument", arg_m, 8000);
    begin
      logic [15:0] held;
      logic held_f;
      held = result; held_f = out_of_range;
      repeat (6) @(negedge clk);
      check(result === held, "R7", "result hold", int'(result), int'(held));
      check(out_of_range === held_f, "R7", "flag hold",
            int'(out_of_range), int'(held_f));
      check(busy === 1'b0, "R5", "no extra busy", int'(busy), 0);
    end

    // R7: new start with out-of-range, then hold across idle
    run_one(20000);
    begin
      logic [15:0] h2;
      h2 = result;
      @(negedge clk); arg = 16'sd3; @(negedge clk);
      repeat (4) @(negedge clk);
      check(result === h2, "R7", "hold while idle", int'(result), int'(h2));
      check(out_of_range === 1'b1, "R7", "flag hold", int'(out_of_range), 1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule